// File: doc/BRIEF.md
# Path-Correlated Indirect Target Predictor

This block predicts the destination of indirect calls, such as those used for virtual method dispatch, from two sources: the address of the call site and the recent path the program has taken. One history register, shared by every call site, keeps a few low bits of each of the last resolved targets. A lookup hashes that history with the call-site address into an index of a table of previously seen targets. The table entry gives the predicted target and whether it is valid.

The lookup is combinational. It returns the predicted target, a valid flag and the index it used. The pipeline carries that index with the branch. When the branch resolves, the index comes back together with the actual target and a flag that says whether the prediction missed. The table then updates that exact slot, and the history advances by one target. Entries carry no tags, so histories that alias to one slot share it. A strike bit on each entry delays replacement until the entry has missed twice in a row. A parameter selects the index function: XOR of address and history, or concatenation of the two.

Top module: `ind_target_pred`

## Requirements
- R1: After the asynchronous active-low reset, every table entry is invalid (`lk_valid_o` is 0 for any address) and the history is zero, so the XOR-mode index equals the low IDX_W address bits.
- R2: Each resolve shifts the history left by HIST_BITS and puts bits [HIST_BITS-1:0] of the actual target into bits [HIST_BITS-1:0]. The history keeps the last PATH_LEN targets, the most recent in the low bits, and the oldest drops out. All call sites share the one history.
- R3: In XOR mode, `lk_idx_o` is `lk_pc_i[IDX_W-1:0]` XOR the history. The history is zero-extended from bit 0.
- R4: In concatenation mode, `lk_idx_o` is `{lk_pc_i[IDX_W-CAT_H-1:0], history[CAT_H-1:0]}`.
- R5: With PATH_LEN = 0, `lk_idx_o` is `lk_pc_i[IDX_W-1:0]` in all cases.
- R6: `lk_valid_o` and `lk_target_o` show the valid bit and the stored target of the entry at `lk_idx_o` in the same cycle. The state they show is the state as of the last clock edge.
- R7: A resolve to an invalid entry stores the actual target, marks the entry valid and clears its strike bit.
- R8: A resolve flagged as a mispredict to a valid entry whose strike bit is clear keeps the stored target and sets the strike bit.
- R9: A resolve flagged as a mispredict to a valid entry whose strike bit is set replaces the target and clears the strike bit.
- R10: A resolve that is not a mispredict, to a valid entry, clears the strike bit and keeps the target. A miss, then a hit, then a miss therefore does not replace the target.
- R11: The table is tagless. Any address and history that give the same index read and update the same entry.
- R12: The update goes to `rs_idx_i`, the index captured at lookup. It does not go to an index recomputed from the history at resolve time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_pc_i | input | ADDR_W | Call-site address for lookup |
| lk_target_o | output | ADDR_W | Predicted target |
| lk_valid_o | output | 1 | Predicted target is valid |
| lk_idx_o | output | IDX_W | Table index used, carried to resolve |
| rs_valid_i | input | 1 | Resolve request |
| rs_idx_i | input | IDX_W | Index captured at lookup |
| rs_target_i | input | ADDR_W | Actual target |
| rs_mispredict_i | input | 1 | The lookup for this branch mispredicted |

## Verification
The bench targets hysteresis sequences: a first miss, a second miss, and a miss-hit-miss sequence. A design with the policy wrong would either replace after a single miss or never clear its strike. Shift order and drop-out are checked with fixed nibble targets, so a design that shifts the wrong way or keeps the oldest target would show a wrong index. Aliased addresses check that the tagless entries really are shared. Resolves that arrive a cycle late, after the history has moved, show whether an update lands on the carried index or on a recomputed one.

// File: rtl/itp_pkg.sv
package itp_pkg;
  typedef enum logic {
    HASH_XOR = 1'b0,
    HASH_CAT = 1'b1
  } hash_mode_e;
endpackage

// File: rtl/itp_path_hist.sv
module itp_path_hist #(
  parameter int HIST_BITS = 4,
  parameter int PATH_LEN  = 2,
  localparam int HW   = HIST_BITS * PATH_LEN,
  localparam int HW_E = (HW > 0) ? HW : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic [HIST_BITS-1:0] tgt_bits_i,
  output logic [HW_E-1:0]      hist_o
);
  if (HW == 0) begin : g_none
    logic unused_ports;
    assign unused_ports = ^{shift_i, tgt_bits_i, clk_i, rst_ni};
    assign hist_o = '0;
  end else if (HW == HIST_BITS) begin : g_single
    logic [HW-1:0] hist_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)      hist_q <= '0;
      else if (shift_i) hist_q <= tgt_bits_i;
    assign hist_o = hist_q;

    assert_hist_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |=> hist_o == $past(tgt_bits_i));
  end else begin : g_shift
    logic [HW-1:0] hist_q;
    // newest target in the low bits, oldest falls off the top
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)      hist_q <= '0;
      else if (shift_i) hist_q <= {hist_q[HW-HIST_BITS-1:0], tgt_bits_i};
    assign hist_o = hist_q;

    assert_hist_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |=> (hist_o[HIST_BITS-1:0] == $past(tgt_bits_i)) &&
                  (hist_o[HW-1:HIST_BITS] == $past(hist_o[HW-HIST_BITS-1:0])));
    assert_hist_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !shift_i |=> $stable(hist_o));
  end
endmodule

// File: rtl/itp_index_hash.sv
module itp_index_hash
  import itp_pkg::*;
#(
  parameter int         IDX_W     = 10,
  parameter int         HIST_W    = 8,
  parameter int         CAT_H     = 8,
  parameter hash_mode_e HASH_MODE = HASH_XOR,
  localparam int HW_E = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic [IDX_W-1:0] pc_i,
  input  logic [HW_E-1:0]  hist_i,
  output logic [IDX_W-1:0] idx_o
);
  if (HIST_W == 0) begin : g_pc_only
    logic unused_hist;
    assign unused_hist = ^hist_i;
    assign idx_o = pc_i;
  end else if (HASH_MODE == HASH_XOR) begin : g_xor
    logic [IDX_W-1:0] hist_ext;
    always_comb begin
      hist_ext = '0;
      hist_ext[HIST_W-1:0] = hist_i;
    end
    assign idx_o = pc_i ^ hist_ext;
  end else if (CAT_H == 0) begin : g_cat_none
    logic unused_hist;
    assign unused_hist = ^hist_i;
    assign idx_o = pc_i;
  end else begin : g_cat
    logic unused_hist;
    assign unused_hist = ^{1'b0, hist_i};
    assign idx_o = {pc_i[IDX_W-CAT_H-1:0], hist_i[CAT_H-1:0]};
  end
endmodule

// File: rtl/itp_target_table.sv
module itp_target_table #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_target_o,
  input  logic              upd_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic              upd_miss_i
);
  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  strike_q;
  logic [ADDR_W-1:0] tgt_q [DEPTH];
  logic              cur_valid, cur_strike, do_write;

  assign cur_valid  = valid_q[upd_idx_i];
  assign cur_strike = strike_q[upd_idx_i];
  // fill an empty slot, or replace only after two misses in a row
  assign do_write   = upd_i && (!cur_valid || (upd_miss_i && cur_strike));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      valid_q  <= '0;
      strike_q <= '0;
    end else if (upd_i) begin
      valid_q[upd_idx_i]  <= 1'b1;
      strike_q[upd_idx_i] <= cur_valid && upd_miss_i && !cur_strike;
    end

  always_ff @(posedge clk_i)
    if (do_write) tgt_q[upd_idx_i] <= upd_target_i;

  assign rd_valid_o  = valid_q[rd_idx_i];
  assign rd_target_o = tgt_q[rd_idx_i];

  assert_install_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !valid_q[upd_idx_i] |=>
      valid_q[$past(upd_idx_i)] && !strike_q[$past(upd_idx_i)] &&
      tgt_q[$past(upd_idx_i)] == $past(upd_target_i));
  assert_first_miss_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && valid_q[upd_idx_i] && !strike_q[upd_idx_i] && upd_miss_i |=>
      strike_q[$past(upd_idx_i)] && tgt_q[$past(upd_idx_i)] == $past(tgt_q[upd_idx_i]));
  assert_second_miss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && valid_q[upd_idx_i] && strike_q[upd_idx_i] && upd_miss_i |=>
      !strike_q[$past(upd_idx_i)] && tgt_q[$past(upd_idx_i)] == $past(upd_target_i));
  assert_hit_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && valid_q[upd_idx_i] && !upd_miss_i |=>
      !strike_q[$past(upd_idx_i)] && tgt_q[$past(upd_idx_i)] == $past(tgt_q[upd_idx_i]));
endmodule

// File: rtl/ind_target_pred.sv
module ind_target_pred
  import itp_pkg::*;
#(
  parameter int         ADDR_W    = 32,
  parameter int         IDX_W     = 10,
  parameter int         HIST_BITS = 4,
  parameter int         PATH_LEN  = 2,
  parameter hash_mode_e HASH_MODE = HASH_XOR,
  parameter int         CAT_H     = HIST_BITS * PATH_LEN,
  localparam int HIST_W = HIST_BITS * PATH_LEN,
  localparam int HW_E   = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic [ADDR_W-1:0] lk_target_o,
  output logic              lk_valid_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  input  logic              rs_valid_i,
  input  logic [IDX_W-1:0]  rs_idx_i,
  input  logic [ADDR_W-1:0] rs_target_i,
  input  logic              rs_mispredict_i
);
  logic [HW_E-1:0] hist;
  logic            unused_pc_hi;

  assign unused_pc_hi = ^lk_pc_i[ADDR_W-1:IDX_W];

  itp_path_hist #(.HIST_BITS(HIST_BITS), .PATH_LEN(PATH_LEN)) u_hist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (rs_valid_i),
    .tgt_bits_i(rs_target_i[HIST_BITS-1:0]),
    .hist_o    (hist)
  );

  itp_index_hash #(
    .IDX_W(IDX_W), .HIST_W(HIST_W), .CAT_H(CAT_H), .HASH_MODE(HASH_MODE)
  ) u_hash (
    .pc_i  (lk_pc_i[IDX_W-1:0]),
    .hist_i(hist),
    .idx_o (lk_idx_o)
  );

  itp_target_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tbl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (lk_idx_o),
    .rd_valid_o  (lk_valid_o),
    .rd_target_o (lk_target_o),
    .upd_i       (rs_valid_i),
    .upd_idx_i   (rs_idx_i),
    .upd_target_i(rs_target_i),
    .upd_miss_i  (rs_mispredict_i)
  );
endmodule

// File: tb/ind_target_pred_tb_top.sv
`timescale 1ns/1ps
module ind_target_pred_tb_top;
  import itp_pkg::*;

  typedef struct packed {
    logic [2:0][9:0] idx;
    logic [2:0]      mp;
    logic [31:0]     tgt;
  } pend_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_target = '0;
  logic [9:0]  rs_idx [3];
  logic        rs_mp [3];
  logic [31:0] pt [3];
  logic        pv [3];
  logic [9:0]  pidx [3];

  int n_chk = 0, n_fail = 0;

  // reference state
  bit          m_v [3][1024];
  bit          m_s [3][1024];
  logic [31:0] m_t [3][1024];
  logic [7:0]  m_h [3];
  pend_t       q [$];
  logic        obs_v [3];
  logic [31:0] obs_t [3];
  logic [9:0]  obs_i [3];

  always #2 clk = ~clk;

  ind_target_pred dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .lk_pc_i(lk_pc), .lk_target_o(pt[0]),
    .lk_valid_o(pv[0]), .lk_idx_o(pidx[0]), .rs_valid_i(rs_valid),
    .rs_idx_i(rs_idx[0]), .rs_target_i(rs_target), .rs_mispredict_i(rs_mp[0]));

  ind_target_pred #(.HASH_MODE(HASH_CAT), .CAT_H(8)) dut_cat_i (
    .clk_i(clk), .rst_ni(rst_ni), .lk_pc_i(lk_pc), .lk_target_o(pt[1]),
    .lk_valid_o(pv[1]), .lk_idx_o(pidx[1]), .rs_valid_i(rs_valid),
    .rs_idx_i(rs_idx[1]), .rs_target_i(rs_target), .rs_mispredict_i(rs_mp[1]));

  ind_target_pred #(.PATH_LEN(0)) dut_p0_i (
    .clk_i(clk), .rst_ni(rst_ni), .lk_pc_i(lk_pc), .lk_target_o(pt[2]),
    .lk_valid_o(pv[2]), .lk_idx_o(pidx[2]), .rs_valid_i(rs_valid),
    .rs_idx_i(rs_idx[2]), .rs_target_i(rs_target), .rs_mispredict_i(rs_mp[2]));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] midx(input int d, input logic [31:0] pc);
    case (d)
      0:       return pc[9:0] ^ {2'b00, m_h[0]};
      1:       return {pc[1:0], m_h[1]};
      default: return pc[9:0];
    endcase
  endfunction

  function automatic string idx_req(input int d);
    case (d)
      0:       return "R3 xor index";
      1:       return "R4 concat index";
      default: return "R5 address-only index";
    endcase
  endfunction

  task automatic mreset();
    for (int d = 0; d < 3; d++) begin
      m_h[d] = '0;
      for (int i = 0; i < 1024; i++) begin m_v[d][i] = 0; m_s[d][i] = 0; end
    end
    q.delete();
  endtask

  task automatic mupdate(input pend_t p);
    for (int d = 0; d < 3; d++) begin
      int i;
      i = int'(p.idx[d]);
      if (!m_v[d][i]) begin m_v[d][i] = 1; m_t[d][i] = p.tgt; m_s[d][i] = 0; end
      else if (p.mp[d]) begin
        if (m_s[d][i]) begin m_t[d][i] = p.tgt; m_s[d][i] = 0; end
        else m_s[d][i] = 1;
      end else m_s[d][i] = 0;
    end
    m_h[0] = {m_h[0][3:0], p.tgt[3:0]};
    m_h[1] = {m_h[1][3:0], p.tgt[3:0]};
    m_h[2] = '0;
  endtask

  // one clock: lookup pc, optionally queue its resolve, optionally resolve the oldest
  task automatic cyc(input logic [31:0] pc, input bit push, input logic [31:0] tgt, input bit pop);
    pend_t e, p;
    logic [9:0] ei;
    bit did_pop;
    e = '0; p = '0; did_pop = 0;
    @(negedge clk);
    lk_pc = pc;
    rs_valid = 1'b0;
    #1;
    for (int d = 0; d < 3; d++) begin
      ei = midx(d, pc);
      obs_v[d] = pv[d]; obs_t[d] = pt[d]; obs_i[d] = pidx[d];
      chk(pidx[d] == ei, idx_req(d), 32'(pidx[d]), 32'(ei));
      chk(pv[d] == m_v[d][int'(ei)], "R6 valid", 32'(pv[d]), 32'(m_v[d][int'(ei)]));
      if (m_v[d][int'(ei)])
        chk(pt[d] == m_t[d][int'(ei)], "R6 target", pt[d], m_t[d][int'(ei)]);
      e.idx[d] = ei;
      e.mp[d]  = !m_v[d][int'(ei)] || (m_t[d][int'(ei)] != tgt);
    end
    e.tgt = tgt;
    if (push) q.push_back(e);
    if (pop && q.size() > 0) begin
      p = q.pop_front();
      did_pop = 1;
      rs_valid = 1'b1;
      rs_target = p.tgt;
      for (int d = 0; d < 3; d++) begin rs_idx[d] = p.idx[d]; rs_mp[d] = p.mp[d]; end
    end
    @(posedge clk);
    if (did_pop) mupdate(p);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    rs_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    mreset();
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lfsr, t1, t2;
    int prev;
    for (int d = 0; d < 3; d++) begin rs_idx[d] = '0; rs_mp[d] = 1'b0; end
    mreset();
    do_reset();

    // R1: everything invalid, history zero
    cyc(32'h0000_0000, 0, 0, 0);
    cyc(32'h0000_0123, 0, 0, 0);
    chk(obs_i[0] == 10'h123, "R1 history zero", 32'(obs_i[0]), 32'h123);
    cyc(32'h0000_03FF, 0, 0, 0);
    for (int d = 0; d < 3; d++) chk(obs_v[d] == 1'b0, "R1 entries invalid", 32'(obs_v[d]), 0);

    // R2: shift order and drop-out, nibbles A, B then C
    cyc(32'h0, 1, 32'h1111_000A, 1);
    cyc(32'h0, 1, 32'h2222_000B, 1);
    cyc(32'h0, 0, 0, 0);
    chk(obs_i[0] == 10'h0AB, "R2 newest in low bits", 32'(obs_i[0]), 32'h0AB);
    cyc(32'h0, 1, 32'h3333_000C, 1);
    cyc(32'h0, 0, 0, 0);
    chk(obs_i[0] == 10'h0BC, "R2 oldest dropped", 32'(obs_i[0]), 32'h0BC);
    cyc(32'h3FF, 0, 0, 0);
    chk(obs_i[0] == 10'h343, "R3 xor with history", 32'(obs_i[0]), 32'h343);
    chk(obs_i[1] == 10'h3BC, "R4 concat with history", 32'(obs_i[1]), 32'h3BC);
    chk(obs_i[2] == 10'h3FF, "R5 address only", 32'(obs_i[2]), 32'h3FF);

    // hysteresis on the address-only instance, call site 0x155
    t1 = 32'hAAAA_0005; t2 = 32'hBBBB_0009;
    cyc(32'h155, 1, t1, 1);
    cyc(32'h155, 1, t2, 1);
    chk(obs_v[2] && obs_t[2] == t1, "R7 install", obs_t[2], t1);
    cyc(32'h155, 1, t2, 1);
    chk(obs_t[2] == t1, "R8 first miss keeps target", obs_t[2], t1);
    cyc(32'h155, 1, t1, 1);
    chk(obs_t[2] == t2, "R9 second miss replaces", obs_t[2], t2);
    cyc(32'h155, 1, t2, 1);
    chk(obs_t[2] == t2, "R8 single miss keeps target", obs_t[2], t2);
    cyc(32'h155, 1, t1, 1);
    cyc(32'h155, 0, 0, 0);
    chk(obs_t[2] == t2, "R10 miss-hit-miss keeps target", obs_t[2], t2);

    // R11: aliasing addresses share the tagless slot
    cyc(32'h555, 0, 0, 0);
    chk(obs_v[2] && obs_t[2] == t2, "R11 alias 0x555", obs_t[2], t2);
    cyc(32'h1155, 0, 0, 0);
    chk(obs_v[2] && obs_t[2] == t2, "R11 alias 0x1155", obs_t[2], t2);

    // R12: late resolves land on the carried index (history 0x95 here)
    cyc(32'h200, 1, 32'hCCCC_0003, 0);
    cyc(32'h300, 1, 32'hDDDD_0007, 1);
    cyc(32'h000, 0, 0, 1);
    cyc(32'h3A2, 0, 0, 0);
    chk(obs_v[0] && obs_t[0] == 32'hDDDD_0007, "R12 carried index second", obs_t[0], 32'hDDDD_0007);
    cyc(32'h2A2, 0, 0, 0);
    chk(obs_v[0] && obs_t[0] == 32'hCCCC_0003, "R12 carried index first", obs_t[0], 32'hCCCC_0003);

    // correlated call sequence with mixed resolve latency
    lfsr = 32'h1D2C_3B4A; prev = 0;
    for (int n = 0; n < 400; n++) begin
      int sel;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sel = int'(lfsr[2:0]);
      cyc(32'h0000_1000 + 32'(sel * 36),
          1,
          32'h8000_0000 + 32'(((sel + prev) & 3) * 64) + 32'(sel),
          (q.size() > 2) || lfsr[5]);
      prev = sel;
    end
    while (q.size() > 0) cyc(32'h0000_1000, 0, 0, 1);

    // R1 again after a mid-run reset
    do_reset();
    cyc(32'h0000_1000, 0, 0, 0);
    for (int d = 0; d < 3; d++) chk(obs_v[d] == 1'b0, "R1 invalid after reset", 32'(obs_v[d]), 0);
    chk(obs_i[0] == 10'h000, "R1 history cleared", 32'(obs_i[0]), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule